// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a clocked system port and an 8K x 8 asynchronous static RAM. It turns single read or write commands into strobe sequences on the memory pins, so that the memory's address, data and enable timing rules hold. The memory has a 13-bit address, a bidirectional byte-wide data bus and three active-low strobes: chip enable, output enable and write enable. Every timing window is a whole number of clock cycles, and each window is set by a parameter.

A command is taken on a valid/ready handshake. The controller latches the address and write data on the accepting edge, so the requester can move on at once. A read holds chip enable and output enable low for the access window. The byte is sampled on the closing edge and returned with a one-cycle done pulse. A write places the address one cycle ahead of the strobes. It then pulls chip enable and write enable low together for the pulse window while driving the byte. After that it holds write enable high for the recovery window before it accepts another command. Output enable stays high for the whole write.

A parameter below one is raised to one cycle.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Out of reset all three strobes are high, `req_ready` is 1 and `rsp_valid` is 0.
- R2: During a read, `mem_ce_n` and `mem_oe_n` are low and `mem_we_n` is high. The strobes fall in the cycle right after acceptance, with `mem_addr` already showing the accepted address.
- R3: A read holds its strobes low for exactly ACCESS_CYC cycles and samples `mem_dq` on the edge that ends them. `rsp_valid` is high for exactly one cycle after that edge, with `rsp_rdata` equal to the sampled byte.
- R4: A write spends one cycle with all strobes high and the new address on `mem_addr`. `mem_ce_n` and `mem_we_n` are then low together for exactly PULSE_CYC cycles, and `mem_we_n` is never low while `mem_ce_n` is high.
- R5: `mem_oe_n` stays high whenever `mem_we_n` is low, so output enable and write enable are never active together.
- R6: `mem_addr` does not change while `mem_we_n` is low.
- R7: The controller drives `mem_dq` only while the write strobes are low, and it drives the byte latched at acceptance.
- R8: After each write pulse, `mem_we_n` stays high and `req_ready` stays low for RECOVER_CYC cycles. `req_ready` returns to 1 in the following cycle.
- R9: A command is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 until that command finishes, and changes to `req_addr` or `req_wdata` after acceptance have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command present |
| req_ready | output | 1 | Controller can take a command |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the command |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse when read data is ready |
| rsp_rdata | output | DATA_W | Byte returned by the last read |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq | inout | DATA_W | Memory data bus |

## Verification
The memory model in the bench returns a corrupted byte until the full access window has passed on a stable address. A controller that samples even one edge early therefore reads back wrong data. The model also counts every address change inside a write, every write pulse that starts before the recovery gap has elapsed, and every cycle where output enable overlaps write enable. A controller that skips the recovery state, or that lets the address register follow the request port, is caught by one of these counters. Caught as well are a pulse or recovery window that is one cycle short, and requester fields that are changed right after acceptance and leak into the bus. The lowest and highest addresses are exercised, and so is a read of a byte never written.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WREC = 3'd4
  } seq_state_e;

  // Any window shorter than one clock is raised to one clock.
  function automatic int unsigned cyc_floor(input int unsigned n);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // The timer holds (window - 1), so it needs clog2 of the longest window.
  function automatic int unsigned timer_width(input int unsigned acc, input int unsigned pul,
                                              input int unsigned rec);
    int unsigned m;
    m = max3(cyc_floor(acc), cyc_floor(pul), cyc_floor(rec));
    return (m > 1) ? $clog2(m) : 1;
  endfunction

  // Number of cycles from acceptance until req_ready rises again.
  function automatic int unsigned write_busy_cycles(input int unsigned pul, input int unsigned rec);
    return 1 + cyc_floor(pul) + cyc_floor(rec);
  endfunction

  function automatic int unsigned read_busy_cycles(input int unsigned acc);
    return cyc_floor(acc);
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ACC_F = 3,
  parameter int unsigned PUL_F = 2,
  parameter int unsigned REC_F = 2,
  parameter int unsigned CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_fire,
  input  logic          req_write,
  input  logic          tmr_last,
  output logic          req_ready,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          rd_sample,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          dq_oe
);

  localparam logic [CW-1:0] ACC_LD = CW'(ACC_F - 1);
  localparam logic [CW-1:0] PUL_LD = CW'(PUL_F - 1);
  localparam logic [CW-1:0] REC_LD = CW'(REC_F - 1);

  seq_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d      = st_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    rd_sample = 1'b0;
    case (st_q)
      ST_IDLE: if (req_fire) begin
        if (req_write) begin
          st_d = ST_WSET;
        end else begin
          st_d     = ST_RD;
          tmr_load = 1'b1;
          tmr_val  = ACC_LD;
        end
      end
      ST_RD: if (tmr_last) begin
        st_d      = ST_IDLE;
        rd_sample = 1'b1;
      end
      ST_WSET: begin
        st_d     = ST_WPUL;
        tmr_load = 1'b1;
        tmr_val  = PUL_LD;
      end
      ST_WPUL: if (tmr_last) begin
        st_d     = ST_WREC;
        tmr_load = 1'b1;
        tmr_val  = REC_LD;
      end
      ST_WREC: if (tmr_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign ce_n      = !((st_q == ST_RD) || (st_q == ST_WPUL));
  assign oe_n      = (st_q != ST_RD);
  assign we_n      = (st_q != ST_WPUL);
  assign dq_oe     = (st_q == ST_WPUL);

  // Run-length counters that watch the strobes for the timing properties.
  int unsigned hi_run, lo_run, oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= REC_F;
      lo_run <= 0;
      oe_run <= 0;
    end else begin
      if (!we_n)               hi_run <= 0;
      else if (hi_run < REC_F) hi_run <= hi_run + 1;
      lo_run <= we_n ? 0 : lo_run + 1;
      oe_run <= oe_n ? 0 : oe_run + 1;
    end
  end

  assert_rd_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ce_n));
  assert_rd_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (oe_run == ACC_F));
  assert_we_in_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);
  assert_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (lo_run == PUL_F));
  assert_oe_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);
  assert_drive_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!we_n && !ce_n));
  assert_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> (hi_run >= REC_F));
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n && we_n));

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          rd_sample,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (capture) begin
      mem_addr <= req_addr;
      dq_out   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_sample;
      if (rd_sample) rsp_rdata <= dq_in;
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_sample_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |=> rsp_valid);

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned ACCESS_CYC  = 3,
  parameter int unsigned PULSE_CYC   = 2,
  parameter int unsigned RECOVER_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int unsigned ACC_F = cyc_floor(ACCESS_CYC);
  localparam int unsigned PUL_F = cyc_floor(PULSE_CYC);
  localparam int unsigned REC_F = cyc_floor(RECOVER_CYC);
  localparam int unsigned CW    = timer_width(ACCESS_CYC, PULSE_CYC, RECOVER_CYC);

  logic              req_fire;
  logic              tmr_load, tmr_last, rd_sample, dq_oe;
  logic [CW-1:0]     tmr_val;
  logic [DATA_W-1:0] dq_out;

  assign req_fire = req_valid && req_ready;

  sram_seq_fsm #(
    .ACC_F(ACC_F), .PUL_F(PUL_F), .REC_F(REC_F), .CW(CW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .req_fire(req_fire), .req_write(req_write), .tmr_last(tmr_last),
    .req_ready(req_ready), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .rd_sample(rd_sample),
    .ce_n(mem_ce_n), .oe_n(mem_oe_n), .we_n(mem_we_n), .dq_oe(dq_oe)
  );

  sram_cycle_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  sram_io_path #(.AW(ADDR_W), .DW(DATA_W)) io_i (
    .clk(clk), .rst_n(rst_n),
    .capture(req_fire), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_sample(rd_sample), .dq_in(mem_dq),
    .mem_addr(mem_addr), .dq_out(dq_out),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_dq = dq_oe ? dq_out : {DATA_W{1'bz}};

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_write) |=> !req_ready);

endmodule

// File: tb/sram_strobe_ctrl_tb.sv
`timescale 1ns/1ps
module sram_strobe_ctrl_tb_top;

  localparam int unsigned AW  = 13;
  localparam int unsigned DW  = 8;
  localparam int unsigned ACC = 4;
  localparam int unsigned PUL = 3;
  localparam int unsigned REC = 2;
  localparam int unsigned WD_CYCLES = 50000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  wire  [DW-1:0] mem_dq;

  sram_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .ACCESS_CYC(ACC), .PULSE_CYC(PUL), .RECOVER_CYC(REC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  // ---------------- behavioural memory model ----------------
  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return 8'(a) ^ 8'(a >> 5) ^ 8'h5A;
  endfunction

  logic [DW-1:0] store [int];
  int unsigned   rd_age = 0, hi_cnt = 1000, lo_len = 0, last_len = 0;
  int unsigned   err_addr = 0, err_rec = 0, err_cont = 0;
  logic [AW-1:0] prev_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_prev = 1'b0;

  wire rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
  wire wr_act = !mem_ce_n && !mem_we_n;

  function automatic logic [DW-1:0] peek(input logic [AW-1:0] a);
    return store.exists(int'(a)) ? store[int'(a)] : dflt(a);
  endfunction

  wire [DW-1:0] mdl_q = (rd_age + 1 >= ACC) ? peek(mem_addr) : ~peek(mem_addr) ^ 8'h3C;
  assign mem_dq = rd_act ? mdl_q : {DW{1'bz}};

  always @(posedge clk) begin
    prev_addr <= mem_addr;
    if (!rd_act)                                 rd_age <= 0;
    else if (rd_age != 0 && mem_addr != prev_addr) rd_age <= 1;
    else                                         rd_age <= rd_age + 1;

    wr_prev <= wr_act;
    if (wr_act) begin
      if (wr_prev && mem_addr != wr_addr) err_addr <= err_addr + 1;
      wr_addr <= mem_addr;
      wr_data <= mem_dq;
      lo_len  <= wr_prev ? lo_len + 1 : 1;
    end else if (wr_prev) begin
      store[int'(wr_addr)] = wr_data;
      last_len <= lo_len;
    end

    if (mem_we_n) begin
      if (hi_cnt < 1000) hi_cnt <= hi_cnt + 1;
    end else begin
      if (hi_cnt != 0 && hi_cnt < REC) err_rec <= err_rec + 1;
      hi_cnt <= 0;
    end

    if (!mem_ce_n && !mem_oe_n && !mem_we_n) err_cont <= err_cont + 1;
  end

  // ---------------- checking helpers ----------------
  int unsigned nvec = 0, nfail = 0;
  bit finished = 1'b0;
  logic [DW-1:0] shadow [int];

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : dflt(a);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;   // R9: later changes must not matter
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    chk("R4", "setup ce_n", mem_ce_n, 1);
    chk("R4", "setup we_n", mem_we_n, 1);
    chk("R6", "setup addr", mem_addr, a);
    chk("R9", "busy ready", req_ready, 0);
    for (int i = 0; i < PUL; i++) begin
      @(negedge clk);
      chk("R4", "pulse ce_n", mem_ce_n, 0);
      chk("R4", "pulse we_n", mem_we_n, 0);
      chk("R5", "pulse oe_n", mem_oe_n, 1);
      chk("R6", "pulse addr", mem_addr, a);
      chk("R7", "pulse data", mem_dq, d);
    end
    for (int i = 0; i < REC; i++) begin
      @(negedge clk);
      chk("R8", "recovery we_n", mem_we_n, 1);
      chk("R8", "recovery ce_n", mem_ce_n, 1);
      chk("R8", "recovery ready", req_ready, 0);
    end
    @(negedge clk);
    chk("R8", "ready after recovery", req_ready, 1);
    chk("R4", "model pulse length", last_len, PUL);
    shadow[int'(a)] = d;
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    logic [DW-1:0] exp;
    exp = expect_rd(a);
    issue(1'b0, a, 8'h00);
    chk("R2", "read ce_n", mem_ce_n, 0);
    chk("R2", "read oe_n", mem_oe_n, 0);
    chk("R2", "read we_n", mem_we_n, 1);
    chk("R2", "read addr", mem_addr, a);
    chk("R3", "no early done", rsp_valid, 0);
    for (int i = 1; i < ACC; i++) begin
      @(negedge clk);
      chk("R3", "still reading", mem_oe_n, 0);
      chk("R3", "no early done", rsp_valid, 0);
    end
    @(negedge clk);
    chk("R3", "done pulse", rsp_valid, 1);
    chk("R3", "read data", rsp_rdata, exp);
    chk("R3", "strobes released", mem_oe_n, 1);
    @(negedge clk);
    chk("R3", "done one cycle", rsp_valid, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk("R1", "reset ce_n", mem_ce_n, 1);
    chk("R1", "reset oe_n", mem_oe_n, 1);
    chk("R1", "reset we_n", mem_we_n, 1);
    chk("R1", "reset ready", req_ready, 1);
    chk("R1", "reset rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_basic();
    do_write(13'h0123, 8'hA5);
    do_read(13'h0123);
  endtask

  task automatic t_bounds();
    do_write(13'h0000, 8'h01);
    do_write(13'h1FFF, 8'hFE);
    do_read(13'h1FFF);
    do_read(13'h0000);
  endtask

  task automatic t_back_to_back();
    for (int i = 0; i < 4; i++) do_write(13'(16'h0800 + i), 8'(8'h30 + 17 * i));
    for (int i = 3; i >= 0; i--) do_read(13'(16'h0800 + i));
  endtask

  task automatic t_overwrite_and_blank();
    do_write(13'h0123, 8'h3C);
    do_read(13'h0123);
    do_read(13'h1555);   // never written: default contents
  endtask

  task automatic t_model_flags();
    chk("R6", "model addr changes", err_addr, 0);
    chk("R8", "model recovery violations", err_rec, 0);
    chk("R5", "model oe/we overlap", err_cont, 0);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      nvec++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_bounds();
    t_back_to_back();
    t_overwrite_and_blank();
    t_model_flags();
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule